// File: doc/BRIEF.md
# Background MDIO Link Poller

This block runs the two-wire management bus without any help from a processor. It makes its own management clock from the system clock and sends one status-register read frame after another. The frames go to PHY addresses 0 through 31 in a fixed round. From each answer it learns two things: whether a PHY is present at that address, and, for the PHYs the host has selected, whether their link is up.

When a selected PHY's link bit differs from the value the block last stored, the block sets a sticky event bit for that address. The host reads three bitmaps: present PHYs, link state and latched events. It sets a selection mask, a clock divider and an interrupt enable mask. It clears events by pulsing ones on a clear vector. A single interrupt line is high whenever an enabled event bit is set. The host never has to run the slow serial transactions itself.

Top module: `mdio_link_mon`

## Requirements
- R1: After reset `mdc` is low, `alive`, `link` and `evt` are all zero and `irq` is low.
- R2: Each half period of `mdc` lasts `clk_div`+1 system clock cycles.
- R3: Each frame spans 64 `mdc` periods. The block drives the following bits, presented after a falling edge and valid at the next rising edge: 32 ones, then 0 1 (start), then 1 0 (read), then the PHY address MSB first, then register address 00001 MSB first. For the remaining 18 bits `mdio_oe` is low.
- R4: Consecutive frames address PHYs 0, 1, … 31 and then wrap to 0.
- R5: The block samples `mdio_i` on the rising edge of the 48th bit of a frame (index 47, the second turnaround bit). If it is low, `alive[a]` is set at the rising edge of the frame's last bit; if it is high, `alive[a]` is cleared there.
- R6: For an alive PHY whose `sel_mask` bit is 1, `link[a]` takes status bit 2. That is the 14th data bit, at frame index 61, with data sent MSB first from index 48.
- R7: When R6 changes the value of `link[a]`, `evt[a]` is set and stays set.
- R8: A one on `evt_clr[i]` clears `evt[i]` on the next clock edge. A new event at the same edge wins over the clear.
- R9: `irq` is high exactly when some bit of `evt & irq_en` is set.
- R10: For a PHY whose `sel_mask` bit is 0, or one that does not answer, neither `link` nor `evt` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-period length of `mdc` minus one, in clock cycles |
| sel_mask | input | 32 | PHYs whose link state is tracked |
| irq_en | input | 32 | Per-address interrupt enable |
| evt_clr | input | 32 | Write-one-to-clear pulses for `evt` |
| mdio_i | input | 1 | Management data from the bus |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data to the bus |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| alive | output | 32 | PHY-present bitmap |
| link | output | 32 | Link-state bitmap |
| evt | output | 32 | Sticky link-change events |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `sel_mask` does not change in the cycle where a frame commits its result. They also assume that clear pulses on `evt_clr` are short. Under those conditions, link bits outside the mask stay stable, and an event bit can fall only after a clear. The bench changes `sel_mask` only while idle in reset setup. It issues clears and changes the simulated PHYs' answers only at bit 20 of a frame, which is far from the turnaround, link-bit and commit sampling points. The simulated PHYs release the line to one during turnaround and drive a fixed status word with bit 2 set to their link state.

// File: rtl/mdio_link_mon.sv
module mdio_link_mon #(
  parameter int          DIV_W    = 8,
  parameter logic [4:0]  STAT_REG = 5'd1,
  parameter int          LINK_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [31:0]      sel_mask,
  input  logic [31:0]      irq_en,
  input  logic [31:0]      evt_clr,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [31:0]      alive,
  output logic [31:0]      link,
  output logic [31:0]      evt,
  output logic             irq
);
  localparam int LAST_IDX = 63;
  localparam int TA_IDX   = 47;
  localparam int DRV_END  = 46;
  localparam int LINK_IDX = 48 + 15 - LINK_BIT;

  logic [DIV_W-1:0] div_q;
  logic             mdc_q, ta_q, lnk_q;
  logic [5:0]       bit_q;
  logic [4:0]       addr_q;
  logic [31:0]      alive_q, link_q, evt_q;

  wire        tick   = div_q >= clk_div;
  wire        rise   = tick & ~mdc_q;
  wire        fall   = tick & mdc_q;
  wire        commit = rise && (bit_q == 6'(LAST_IDX));
  wire [31:0] hit    = 32'd1 << addr_q;
  wire [31:0] upd    = (commit && !ta_q) ? (hit & sel_mask) : 32'd0;
  wire [31:0] chg    = upd & (link_q ^ {32{lnk_q}});
  wire [5:0]  aoff   = 6'd40 - bit_q;
  wire [5:0]  roff   = 6'd45 - bit_q;

  always_comb begin
    if (bit_q < 6'd32)      mdio_o = 1'b1;
    else if (bit_q < 6'd36) mdio_o = (bit_q == 6'd33) || (bit_q == 6'd34);
    else if (bit_q < 6'd41) mdio_o = addr_q[aoff[2:0]];
    else if (bit_q < 6'd46) mdio_o = STAT_REG[roff[2:0]];
    else                    mdio_o = 1'b0;
  end

  assign mdio_oe = bit_q < 6'(DRV_END);
  assign mdc     = mdc_q;
  assign alive   = alive_q;
  assign link    = link_q;
  assign evt     = evt_q;
  assign irq     = |(evt_q & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      mdc_q   <= 1'b0;
      bit_q   <= '0;
      addr_q  <= '0;
      ta_q    <= 1'b1;
      lnk_q   <= 1'b0;
      alive_q <= '0;
      link_q  <= '0;
      evt_q   <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise && bit_q == 6'(TA_IDX))   ta_q  <= mdio_i;
      if (rise && bit_q == 6'(LINK_IDX)) lnk_q <= mdio_i;
      if (fall) begin
        bit_q <= bit_q + 1'b1;
        if (bit_q == 6'(LAST_IDX)) addr_q <= addr_q + 1'b1;
      end
      if (commit) alive_q[addr_q] <= ~ta_q;
      link_q <= (link_q & ~upd) | (upd & {32{lnk_q}});
      evt_q  <= (evt_q & ~evt_clr) | chg;
    end
  end

  assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_q) & ~evt_q & ~$past(evt_clr)) == 32'd0));

  assert_evt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~(link_q ^ $past(link_q))) == 32'd0));

  assert_link_unsel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((link_q ^ $past(link_q)) & ~$past(sel_mask)) == 32'd0));

  assert_link_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((link_q ^ $past(link_q)) & ~alive_q) == 32'd0));

  assert_oe_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> $fell(mdc_q));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 32'd0) |-> !irq);
endmodule

// File: tb/mdio_link_mon_bench.sv
`timescale 1ns/1ps
module mdio_link_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic [31:0] sel_mask = ~(32'd1 << 5);
  logic [31:0] irq_en = 32'd1 << 2;
  logic [31:0] evt_clr = '0;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic [31:0] alive, link, evt;

  mdio_link_mon u_mdio_link_mon (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .sel_mask(sel_mask),
    .irq_en(irq_en), .evt_clr(evt_clr), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .alive(alive), .link(link),
    .evt(evt), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, rc = 0;
  logic [31:0] phy_on  = (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 31);
  logic [31:0] phy_lnk = (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 31);
  logic [31:0] alive_m = '0, link_m = '0, evt_m = '0;
  logic [95:0] scb[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(input int b, input logic [4:0] a);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, 2'b10, a, 5'b00001, 18'b0};
    return f[63-b];
  endfunction

  // bus side: PHY model and scoreboard driver
  always @(negedge mdc) begin
    int nb, na;
    logic [15:0] sw;
    nb = rc % 64;
    na = (rc / 64) % 32;
    sw = 16'h7809 | (16'(phy_lnk[na]) << 2);
    if (!phy_on[na] || nb < 46) mdio_i = 1'b1;
    else if (nb == 46) mdio_i = 1'b1;
    else if (nb == 47) mdio_i = 1'b0;
    else mdio_i = sw[15 - (nb - 48)];
    if (nb == 63) begin
      if (phy_on[na]) begin
        alive_m[na] = 1'b1;
        if (sel_mask[na]) begin
          if (link_m[na] != phy_lnk[na]) evt_m[na] = 1'b1;
          link_m[na] = phy_lnk[na];
        end
      end else alive_m[na] = 1'b0;
      scb.push_back({alive_m, link_m, evt_m});
    end
  end

  // frame checker (R3, R4) and monitor popping the scoreboard
  always @(posedge mdc) begin
    int b, a;
    logic [95:0] e;
    b = rc % 64;
    a = (rc / 64) % 32;
    chk("R3 oe", 32'(mdio_oe), 32'(b < 46));
    if (b < 46) chk("R3/R4 frame bit", 32'(mdio_o), 32'(frame_bit(b, 5'(a))));
    rc++;
    if (b == 63) begin
      @(negedge clk);
      if (scb.size() == 0) chk("scoreboard empty", 32'd1, 32'd0);
      else begin
        e = scb.pop_front();
        chk("R5 alive", alive, e[95:64]);
        chk("R6/R10 link", link, e[63:32]);
        chk("R7/R10 evt", evt, e[31:0]);
        chk("R9 irq", 32'(irq), 32'(|(e[31:0] & irq_en)));
      end
    end
  end

  task automatic sync_mid();
    do @(negedge mdc); while (rc % 64 != 20);
    @(negedge clk);
  endtask

  task automatic run_until(input int n);
    while (rc < n) @(posedge clk);
  endtask

  task automatic clear_evt(input logic [31:0] m);
    sync_mid();
    evt_clr = m;
    evt_m &= ~m;
    @(negedge clk);
    evt_clr = '0;
    chk("R8 evt cleared", evt, evt_m);
    chk("R8/R9 irq after clear", 32'(irq), 32'(|(evt_m & irq_en)));
  endtask

  task automatic measure(input int exp_half);
    realtime t0, t1;
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk("R2 mdc period", 32'($rtoi((t1 - t0) / 5.0)), 32'(2 * exp_half));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mdc", 32'(mdc), 32'd0);
    chk("R1 alive", alive, 32'd0);
    chk("R1 link", link, 32'd0);
    chk("R1 evt", evt, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    measure(2);
    run_until(64 * 32);
    chk("R7 events after first round", evt, (32'd1 << 2) | (32'd1 << 31));
    chk("R10 unselected PHY 5 link", 32'(link[5]), 32'd0);
    chk("R9 irq on enabled event", 32'(irq), 32'd1);
    clear_evt(32'hFFFF_FFFF);
    chk("R9 irq low after clear", 32'(irq), 32'd0);
    sync_mid();
    phy_lnk[9] = 1'b1;
    phy_lnk[2] = 1'b0;
    phy_on[31] = 1'b0;
    run_until(64 * 64);
    chk("R5 PHY 31 gone", 32'(alive[31]), 32'd0);
    chk("R10 PHY 31 link kept", 32'(link[31]), 32'd1);
    chk("R7 new events", evt, (32'd1 << 2) | (32'd1 << 9));
    irq_en = '0;
    @(negedge clk);
    chk("R9 irq masked", 32'(irq), 32'd0);
    irq_en = 32'd1 << 9;
    @(negedge clk);
    chk("R9 irq other enable", 32'(irq), 32'd1);
    clear_evt(32'd1 << 2);
    sync_mid();
    clk_div = 8'd3;
    measure(4);
    sync_mid();
    phy_lnk[9] = 1'b0;
    phy_on[31] = 1'b1;
    run_until(64 * 96 + 2);
    chk("R4/R5 PHY 31 back", 32'(alive[31]), 32'd1);
    chk("R7 link drop event", evt, 32'd1 << 9);
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule